// File: doc/BRIEF.md
# Pixel Region Triggered Hit Buffer

This block is the digital logic of one readout region shared by four analog pixel channels. Each channel delivers a discriminator level. The region measures each pulse's time-over-threshold (ToT) in clock cycles and keeps the result inside the region while a programmable trigger latency runs. Only hits that a trigger confirms at the exact end of that latency leave the region. Every other hit is erased in place, so the periphery sees only a small share of the activity.

The region has five hit slots. A slot holds one 4-bit ToT value for each pixel and has one latency down-counter of its own. A discriminator rise claims the lowest free slot. Every pixel that rises in the same clock cycle joins that slot. When the latency expires, the trigger input decides whether the slot is read out or freed. A slot that is read out delivers one word per hit pixel over a ready/valid output, and each word carries the pixel address and its ToT.

Top module: `pixel_region_buf`

## Requirements
- R1: A synchronous active-high reset empties every slot and clears the overflow flag. After reset, `out_valid_o` and `ovf_o` are 0.
- R2: A pixel's ToT is the number of clock edges at which its discriminator is sampled high. Counting starts at the edge that first sees the rise and continues through the edge at which the latency counter reaches zero. The value is 4 bits wide and stops at 15.
- R3: Let latency L be the value of `lat_cfg_i` at the rising edge that captures the hit. The trigger is sampled at exactly the (L+1)-th clock edge after that edge. If it is 1 there, the hit is read out. If it is 1 only one cycle earlier or one cycle later, the hit is dropped and no word appears.
- R4: Pixels that rise in the same cycle share one slot. Their words come out in ascending pixel address order (address 0 to 3), and each word carries that pixel's own ToT.
- R5: While `out_valid_o` is 1 and `out_ready_i` is 0, the output word and `out_valid_o` stay unchanged. A word is consumed only at an edge where both are 1.
- R6: There are five slots. A rise that finds all five busy is dropped. `ovf_o` then goes to 1 and stays at 1 until reset.
- R7: Every word presented with `out_valid_o` at 1 has a nonzero ToT.
- R8: A pixel that pulses again while its earlier hit is still waiting takes a second slot. Both hits are read out independently, oldest first when their triggers come in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Region clock for ToT counting and latency timing |
| rst | input | 1 | Synchronous active-high reset |
| disc_i | input | 4 | Discriminator level for each pixel |
| lat_cfg_i | input | 8 | Trigger latency in clock cycles |
| trig_i | input | 1 | Trigger level |
| out_ready_i | input | 1 | Downstream accepts a word |
| out_valid_o | output | 1 | A readout word is presented |
| out_addr_o | output | 2 | Pixel address of the word |
| out_tot_o | output | 4 | ToT of the word |
| ovf_o | output | 1 | Sticky flag for a hit lost because no slot was free |

## Verification
The bench places triggers one cycle early, exactly on time and one cycle late. An off-by-one in the latency counter therefore either loses the on-time hit or reads out one of the mistimed hits. It drives four pixels together with different pulse lengths, and also a pulse longer than the counter range. A design that mixes pixels within a slot, orders them wrongly or wraps the counter returns wrong addresses or ToTs. It stalls the output with ready low to catch a word that changes or is lost before acceptance. Finally it holds all five slots busy with one pixel re-firing, so that a sixth hit must be refused, must set the sticky flag and must never appear at the output.

// File: rtl/pixreg_pkg.sv
package pixreg_pkg;

    localparam int DEF_NPIX  = 4;
    localparam int DEF_NSLOT = 5;
    localparam int DEF_TOTW  = 4;
    localparam int DEF_LATW  = 8;

    typedef enum logic [1:0] {
        SL_FREE = 2'd0,
        SL_WAIT = 2'd1,
        SL_READ = 2'd2
    } slot_st_e;

endpackage

// File: rtl/pr_alloc.sv
module pr_alloc #(
    parameter int NSLOT = 5
) (
    input  logic [NSLOT-1:0] busy,
    output logic [NSLOT-1:0] grant,
    output logic             full
);
    always_comb begin
        grant = '0;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (!busy[s]) begin
                grant    = '0;
                grant[s] = 1'b1;
            end
        end
        full = &busy;
    end
endmodule

// File: rtl/pr_slot.sv
module pr_slot
    import pixreg_pkg::*;
#(
    parameter int NPIX = 4,
    parameter int TOTW = 4,
    parameter int LATW = 8,
    localparam int PIXW = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       alloc,
    input  logic [NPIX-1:0]            rise,
    input  logic [NPIX-1:0]            disc,
    input  logic [LATW-1:0]            lat_cfg,
    input  logic                       trig,
    input  logic                       pop,
    input  logic [PIXW-1:0]            pop_pix,
    output slot_st_e                   st,
    output logic [NPIX-1:0][TOTW-1:0]  tot
);
    localparam logic [TOTW-1:0] TOT_MAX = '1;
    localparam logic [TOTW-1:0] TOT_ONE = TOTW'(1);

    logic [LATW-1:0] cnt;
    logic [NPIX-1:0] en;
    logic            others_left;

    // any hit pixel besides the one being popped
    always_comb begin
        others_left = 1'b0;
        for (int p = 0; p < NPIX; p++) begin
            if (tot[p] != '0 && p != int'(pop_pix)) others_left = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SL_FREE;
            cnt <= '0;
            en  <= '0;
            tot <= '0;
        end else begin
            case (st)
                SL_FREE: begin
                    if (alloc) begin
                        st  <= SL_WAIT;
                        cnt <= lat_cfg;
                        en  <= rise;
                        for (int p = 0; p < NPIX; p++)
                            tot[p] <= rise[p] ? TOT_ONE : '0;
                    end
                end
                SL_WAIT: begin
                    if (cnt == '0) begin
                        en <= '0;
                        if (trig) begin
                            st <= SL_READ;
                        end else begin
                            st  <= SL_FREE;
                            tot <= '0;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                        for (int p = 0; p < NPIX; p++) begin
                            if (en[p]) begin
                                if (!disc[p])               en[p]  <= 1'b0;
                                else if (tot[p] != TOT_MAX) tot[p] <= tot[p] + 1'b1;
                            end
                        end
                    end
                end
                SL_READ: begin
                    if (pop) begin
                        tot[pop_pix] <= '0;
                        if (!others_left) st <= SL_FREE;
                    end
                end
                default: st <= SL_FREE;
            endcase
        end
    end
endmodule

// File: rtl/pr_rdsel.sv
module pr_rdsel #(
    parameter int NPIX  = 4,
    parameter int NSLOT = 5,
    parameter int TOTW  = 4,
    localparam int PIXW = (NPIX > 1) ? $clog2(NPIX) : 1,
    localparam int SLW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [NSLOT-1:0]                      rd,
    input  logic [NSLOT-1:0][NPIX-1:0][TOTW-1:0]  tots,
    input  logic                                  ready,
    output logic                                  valid,
    output logic [SLW-1:0]                        sel_slot,
    output logic [PIXW-1:0]                       sel_pix,
    output logic [TOTW-1:0]                       sel_tot
);
    logic           held;
    logic [SLW-1:0] held_slot;
    logic [SLW-1:0] low_slot;
    logic           nz_cnt_gt1;
    int             nz_cnt;

    always_comb begin
        low_slot = '0;
        for (int s = NSLOT - 1; s >= 0; s--)
            if (rd[s]) low_slot = SLW'(s);
        sel_slot = held ? held_slot : low_slot;
        valid    = held | (|rd);
        sel_pix  = '0;
        nz_cnt   = 0;
        for (int p = NPIX - 1; p >= 0; p--) begin
            if (tots[sel_slot][p] != '0) begin
                sel_pix = PIXW'(p);
                nz_cnt  = nz_cnt + 1;
            end
        end
        nz_cnt_gt1 = (nz_cnt > 1);
        sel_tot    = tots[sel_slot][sel_pix];
    end

    // keep serving one slot until its last word is accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= 1'b0;
            held_slot <= '0;
        end else begin
            held      <= valid && !(ready && !nz_cnt_gt1);
            held_slot <= sel_slot;
        end
    end
endmodule

// File: rtl/pixel_region_buf.sv
module pixel_region_buf
    import pixreg_pkg::*;
#(
    parameter int NPIX  = DEF_NPIX,
    parameter int NSLOT = DEF_NSLOT,
    parameter int TOTW  = DEF_TOTW,
    parameter int LATW  = DEF_LATW,
    localparam int PIXW = (NPIX > 1) ? $clog2(NPIX) : 1,
    localparam int SLW  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIX-1:0] disc_i,
    input  logic [LATW-1:0] lat_cfg_i,
    input  logic            trig_i,
    input  logic            out_ready_i,
    output logic            out_valid_o,
    output logic [PIXW-1:0] out_addr_o,
    output logic [TOTW-1:0] out_tot_o,
    output logic            ovf_o
);
    logic [NPIX-1:0]                      disc_q;
    logic [NPIX-1:0]                      rise;
    logic                                 any_rise;
    logic [NSLOT-1:0]                     busy, grant, rd, pop;
    logic                                 full;
    logic [SLW-1:0]                       sel_slot;
    slot_st_e                             st_v [NSLOT];
    logic [NSLOT-1:0][NPIX-1:0][TOTW-1:0] tot_v;

    assign rise     = disc_i & ~disc_q;
    assign any_rise = |rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            disc_q <= '0;
            ovf_o  <= 1'b0;
        end else begin
            disc_q <= disc_i;
            if (any_rise && full) ovf_o <= 1'b1;
        end
    end

    pr_alloc #(.NSLOT(NSLOT)) u_alloc (
        .busy (busy),
        .grant(grant),
        .full (full)
    );

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign busy[s] = (st_v[s] != SL_FREE);
        assign rd[s]   = (st_v[s] == SL_READ);
        assign pop[s]  = out_valid_o && out_ready_i && (sel_slot == SLW'(s));

        pr_slot #(.NPIX(NPIX), .TOTW(TOTW), .LATW(LATW)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .alloc  (grant[s] && any_rise),
            .rise   (rise),
            .disc   (disc_i),
            .lat_cfg(lat_cfg_i),
            .trig   (trig_i),
            .pop    (pop[s]),
            .pop_pix(out_addr_o),
            .st     (st_v[s]),
            .tot    (tot_v[s])
        );
    end

    pr_rdsel #(.NPIX(NPIX), .NSLOT(NSLOT), .TOTW(TOTW)) u_rdsel (
        .clk     (clk),
        .rst     (rst),
        .rd      (rd),
        .tots    (tot_v),
        .ready   (out_ready_i),
        .valid   (out_valid_o),
        .sel_slot(sel_slot),
        .sel_pix (out_addr_o),
        .sel_tot (out_tot_o)
    );
endmodule

// File: rtl/pixel_region_buf_chk.sv
module pixel_region_buf_chk #(
    parameter int PIXW = 2,
    parameter int TOTW = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            out_valid_o,
    input logic            out_ready_i,
    input logic [PIXW-1:0] out_addr_o,
    input logic [TOTW-1:0] out_tot_o,
    input logic            ovf_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid_o && !ovf_o));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !out_ready_i) |=>
            (out_valid_o && $stable(out_addr_o) && $stable(out_tot_o)));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    assert_tot_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (out_tot_o != '0));
endmodule

bind pixel_region_buf pixel_region_buf_chk #(.PIXW(PIXW), .TOTW(TOTW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .out_addr_o (out_addr_o),
    .out_tot_o  (out_tot_o),
    .ovf_o      (ovf_o)
);

// File: tb/tb_pixel_region_buf.sv
module tb_pixel_region_buf;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] disc = '0;
    logic [7:0] lat = 8'd5;
    logic       trig = 1'b0;
    logic       ready = 1'b1;
    logic       out_valid;
    logic [1:0] out_addr;
    logic [3:0] out_tot;
    logic       ovf;

    int n_chk = 0;
    int n_bad = 0;
    int exp_addr[$];
    int exp_tot[$];

    always #5 clk = ~clk;

    pixel_region_buf dut (
        .clk(clk), .rst(rst), .disc_i(disc), .lat_cfg_i(lat), .trig_i(trig),
        .out_ready_i(ready), .out_valid_o(out_valid), .out_addr_o(out_addr),
        .out_tot_o(out_tot), .ovf_o(ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    // inputs change 2 ns after a rising edge; step k values are sampled at edge k
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // monitor: compare every accepted word against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid && ready) begin
            chk(out_tot != 0, "R7 nonzero tot", int'(out_tot), 1);
            if (exp_addr.size() == 0) begin
                chk(1'b0, "R3 unexpected word addr", int'(out_addr), -1);
            end else begin
                int ea, et;
                ea = exp_addr.pop_front();
                et = exp_tot.pop_front();
                chk(int'(out_addr) == ea, "R4 word addr", int'(out_addr), ea);
                chk(int'(out_tot) == et, "R2 word tot", int'(out_tot), et);
            end
        end
    end

    task automatic expect_word(input int a, input int t);
        exp_addr.push_back(a);
        exp_tot.push_back(t);
    endtask

    task automatic drained(input string req);
        repeat (8) step();
        @(negedge clk);
        chk(exp_addr.size() == 0, req, exp_addr.size(), 0);
        chk(out_valid == 1'b0, req, int'(out_valid), 0);
    endtask

    // one group of pixels rising together; trig_k < 0 means no trigger
    task automatic hit(input logic [3:0] mask, input int l0, input int l1,
                       input int l2, input int l3, input int L, input int trig_k);
        int lens[4];
        lens = '{l0, l1, l2, l3};
        lat = 8'(L);
        if (trig_k == L + 1) begin
            for (int p = 0; p < 4; p++) begin
                if (mask[p]) begin
                    int t;
                    t = lens[p];
                    if (t > L + 1) t = L + 1;
                    if (t > 15) t = 15;
                    expect_word(p, t);
                end
            end
        end
        for (int k = 0; k <= L + 3 && k <= trig_k + 2 || k < 40 && k <= L + 3; k++) begin
            for (int p = 0; p < 4; p++) disc[p] = mask[p] && (k < lens[p]);
            trig = (k == trig_k);
            step();
        end
        disc = '0;
        trig = 1'b0;
    endtask

    initial begin
        ready = 1'b1;
        repeat (3) step();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", int'(out_valid), 0);
        chk(ovf == 1'b0, "R1 ovf after reset", int'(ovf), 0);
        rst = 1'b0;
        step();

        // R2/R3: single pixel, trigger on time
        hit(4'b0100, 0, 0, 4, 0, 5, 6);
        drained("R3 on-time drain");

        // R3: trigger one cycle early and one cycle late -> dropped
        hit(4'b0001, 3, 0, 0, 0, 5, 5);
        drained("R3 early trigger dropped");
        hit(4'b0001, 3, 0, 0, 0, 5, 7);
        drained("R3 late trigger dropped");

        // R4: all pixels together, distinct lengths, ascending order
        hit(4'b1111, 1, 7, 3, 2, 10, 11);
        drained("R4 shared slot drain");

        // R2: saturation at 15
        hit(4'b0010, 0, 20, 0, 0, 25, 26);
        drained("R2 saturation drain");

        // R8: same pixel twice during latency, two slots
        lat = 8'd8;
        expect_word(0, 2);
        expect_word(0, 3);
        for (int k = 0; k < 24; k++) begin
            disc[0] = (k < 2) || (k >= 4 && k < 7);
            trig = (k == 9) || (k == 13);
            step();
        end
        disc = '0;
        trig = 1'b0;
        drained("R8 re-fire drain");

        // R5: stall with ready low
        ready = 1'b0;
        lat = 8'd5;
        for (int k = 0; k < 7; k++) begin
            disc = (k < 3) ? 4'b1010 : 4'b0000;
            trig = (k == 6);
            step();
        end
        trig = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(out_valid == 1'b1, "R5 valid held", int'(out_valid), 1);
            chk(out_addr == 2'd1, "R5 addr held", int'(out_addr), 1);
            chk(out_tot == 4'd3, "R5 tot held", int'(out_tot), 3);
            step();
        end
        expect_word(1, 3);
        expect_word(3, 3);
        ready = 1'b1;
        drained("R5 drain after stall");

        // R6: five busy slots, sixth hit refused
        lat = 8'd30;
        for (int i = 0; i < 5; i++) expect_word(0, 1);
        for (int k = 0; k < 50; k++) begin
            disc[0] = (k < 12) && (k % 2 == 0);
            trig = (k >= 31) && (k <= 41) && (k % 2 == 1);
            step();
            if (k == 9) begin
                @(negedge clk);
                chk(ovf == 1'b0, "R6 no ovf with five hits", int'(ovf), 0);
            end
            if (k == 12) begin
                @(negedge clk);
                chk(ovf == 1'b1, "R6 ovf on sixth hit", int'(ovf), 1);
            end
        end
        disc = '0;
        trig = 1'b0;
        drained("R6 only five words");
        @(negedge clk);
        chk(ovf == 1'b1, "R6 ovf sticky", int'(ovf), 1);

        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end
endmodule